// File: doc/BRIEF.md
# Sleep Mode Clock Gating Controller

This block is the power manager of a small microcontroller. When the core raises a sleep request, the block looks at a 3-bit mode code and moves to one of three sleep states. Each state switches off its own group of clock enables: CPU, flash, I/O, ADC and oscillator. While asleep, the block compares incoming wake events with the set that the current state accepts. When an accepted event arrives, it turns the clocks back on. In the deepest state the oscillator is off. Leaving that state passes through a warm-up phase, during which only the oscillator runs, for a programmable number of slow ticks.

All pins are plain control and status lines. There is no data stream and therefore no back-pressure. The wake events, the level lines and the slow tick are assumed to be already synchronous to `clk`. The block's own flops run on a clock that is never gated. Any reset (external, watchdog or brown-out, all merged onto `rst_n`) returns the block to the running state at once, with no warm-up.

Top module: `sleep_clk_ctrl`

## Requirements
- R1: After reset, all five clock enables are 1 and `adc_start` is 0.
- R2: A sleep request with mode code 000 (light sleep) turns off the CPU and flash enables and keeps the I/O, ADC and oscillator enables on. The change is visible from the cycle after the request.
- R3: Mode code 001 (converter-quiet sleep) turns off the CPU, flash and I/O enables and keeps the ADC and oscillator enables on.
- R4: Mode code 010 (deep sleep) turns off all five enables, including `osc_en`.
- R5: A sleep request with a mode code from 011 to 111 is ignored, and so is any sleep request made while asleep. All enables keep their values.
- R6: In light sleep, any bit of `wake_src` or any `ext_lvl` line wakes the block, and all enables return to 1 on the next cycle.
- R7: In converter-quiet sleep, only `wake_src` bit 0 (conversion done), bit 1 (timer) and bit 2 (memory ready), or any `ext_lvl` line, wake the block. Bit 3 (PWM), bit 4 (serial transmit done) and bit 5 (other internal) have no effect.
- R8: In deep sleep, only `wake_src` bit 3 (PWM) or a qualified level (R9) wakes the block. All other `wake_src` bits have no effect.
- R9: In deep sleep, an `ext_lvl` line wakes the block only after HOLD_TICKS (4) `slow_tick` pulses have arrived while some line stays high. A cycle in which all lines are low restarts the count, and a high level with no tick pulses never wakes the block.
- R10: On a wake from deep sleep, the block enters warm-up: `osc_en` is 1 and the other enables are 0. The value on `warmup_sel` is captured at the wake. Warm-up ends on the cycle after that many `slow_tick` pulses have arrived (the next cycle if the value is 0), and then all enables are 1.
- R11: `adc_start` pulses for exactly one cycle, together with the changed enables, when light or converter-quiet sleep is entered while `adc_en` is 1. It never pulses on deep-sleep entry or when `adc_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low merged reset |
| sleep_req | input | 1 | Sleep request pulse from the core |
| mode_sel | input | 3 | Sleep mode code |
| adc_en | input | 1 | ADC is enabled |
| wake_src | input | 6 | Wake events: 0 conv done, 1 timer, 2 mem ready, 3 PWM, 4 serial tx done, 5 other |
| ext_lvl | input | EXT_N (4) | External level interrupt lines 0..3 |
| slow_tick | input | 1 | One-cycle tick from the free-running slow oscillator |
| warmup_sel | input | WARM_W (4) | Warm-up length in ticks |
| cpu_clk_en | output | 1 | CPU clock enable |
| flash_clk_en | output | 1 | Flash clock enable |
| io_clk_en | output | 1 | I/O clock enable |
| adc_clk_en | output | 1 | ADC clock enable |
| osc_en | output | 1 | Main oscillator enable |
| adc_start | output | 1 | One-cycle conversion start strobe |

## Verification
A wrong state register shows up as a wrong enable pattern one cycle after the sleep request or wake event that caused it. Each sleep state has its own 5-bit enable pattern, so the state can be read at the ports without extra visibility. A wrong wake mask shows up as the block staying asleep, or waking, one cycle after a single-source pulse. A miscounting hold or warm-up counter moves the wake or the release by whole tick pulses, so the bench checks the pattern after every tick.

// File: rtl/slp_pkg.sv
package slp_pkg;

  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_LIGHT  = 3'd1,
    ST_QUIET  = 3'd2,
    ST_DEEP   = 3'd3,
    ST_WARMUP = 3'd4
  } slp_state_e;

  localparam int SRC_N     = 6;
  localparam int SRC_CONV  = 0;
  localparam int SRC_TIMER = 1;
  localparam int SRC_MEM   = 2;
  localparam int SRC_PWM   = 3;
  localparam int SRC_SER   = 4;
  localparam int SRC_OTHER = 5;

  localparam int CLK_N  = 5;
  localparam int CK_CPU = 0;
  localparam int CK_FLS = 1;
  localparam int CK_IO  = 2;
  localparam int CK_ADC = 3;
  localparam int CK_OSC = 4;

  localparam logic [2:0] CODE_LIGHT = 3'b000;
  localparam logic [2:0] CODE_QUIET = 3'b001;
  localparam logic [2:0] CODE_DEEP  = 3'b010;

  // Edge-type wake sources accepted in each state.
  function automatic logic [SRC_N-1:0] accept_mask(slp_state_e s);
    logic [SRC_N-1:0] m;
    m = '0;
    case (s)
      ST_LIGHT: m = '1;
      ST_QUIET: begin
        m[SRC_CONV]  = 1'b1;
        m[SRC_TIMER] = 1'b1;
        m[SRC_MEM]   = 1'b1;
      end
      ST_DEEP:  m[SRC_PWM] = 1'b1;
      default:  m = '0;
    endcase
    return m;
  endfunction

  // Clock enables kept on in each state.
  function automatic logic [CLK_N-1:0] keep_on(slp_state_e s);
    logic [CLK_N-1:0] k;
    k = '0;
    case (s)
      ST_RUN:    k = '1;
      ST_LIGHT: begin
        k[CK_IO]  = 1'b1;
        k[CK_ADC] = 1'b1;
        k[CK_OSC] = 1'b1;
      end
      ST_QUIET: begin
        k[CK_ADC] = 1'b1;
        k[CK_OSC] = 1'b1;
      end
      ST_WARMUP: k[CK_OSC] = 1'b1;
      default:   k = '0;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/slp_wake_qual.sv
module slp_wake_qual
  import slp_pkg::*;
#(
  parameter int EXT_N      = 4,
  parameter int HOLD_TICKS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  slp_state_e       state,
  input  logic [SRC_N-1:0] src,
  input  logic [EXT_N-1:0] lvl,
  input  logic             tick,
  output logic             wake
);
  localparam int HC_W = $clog2(HOLD_TICKS + 1);
  localparam logic [HC_W-1:0] HC_MAX = HC_W'(HOLD_TICKS);

  logic [HC_W-1:0] hold_cnt;
  logic            lvl_any;
  logic            in_deep;
  logic            src_hit;
  logic            lvl_fast;
  logic            lvl_held;

  assign lvl_any = |lvl;
  assign in_deep = (state == ST_DEEP);

  // Level qualification counter: runs on slow ticks only in deep sleep.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cnt <= '0;
    end else if (!in_deep || !lvl_any) begin
      hold_cnt <= '0;
    end else if (tick && hold_cnt != HC_MAX) begin
      hold_cnt <= hold_cnt + HC_W'(1);
    end
  end

  always_comb begin
    src_hit  = |(src & accept_mask(state));
    lvl_fast = lvl_any && (state == ST_LIGHT || state == ST_QUIET);
    lvl_held = in_deep && lvl_any && (hold_cnt == HC_MAX);
    wake     = src_hit || lvl_fast || lvl_held;
  end

endmodule

// File: rtl/slp_warmup_timer.sv
module slp_warmup_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic         done
);
  logic [W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
    end else if (load) begin
      remain <= load_val;
    end else if (tick && remain != '0) begin
      remain <= remain - W'(1);
    end
  end

  assign done = (remain == '0);

endmodule

// File: rtl/slp_clk_decode.sv
module slp_clk_decode
  import slp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  slp_state_e       state_nx,
  output logic [CLK_N-1:0] en
);
  logic [CLK_N-1:0] keep_nx;

  assign keep_nx = keep_on(state_nx);

  // One flop per enable so gate inputs come straight from registers.
  for (genvar i = 0; i < CLK_N; i++) begin : g_en
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en[i] <= 1'b1;
      else        en[i] <= keep_nx[i];
    end
  end

endmodule

// File: rtl/sleep_clk_ctrl.sv
module sleep_clk_ctrl
  import slp_pkg::*;
#(
  parameter int EXT_N      = 4,
  parameter int HOLD_TICKS = 4,
  parameter int WARM_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_req,
  input  logic [2:0]        mode_sel,
  input  logic              adc_en,
  input  logic [5:0]        wake_src,
  input  logic [EXT_N-1:0]  ext_lvl,
  input  logic              slow_tick,
  input  logic [WARM_W-1:0] warmup_sel,
  output logic              cpu_clk_en,
  output logic              flash_clk_en,
  output logic              io_clk_en,
  output logic              adc_clk_en,
  output logic              osc_en,
  output logic              adc_start
);
  slp_state_e       state_q, state_nx;
  logic             wake;
  logic             warm_done;
  logic             warm_load;
  logic             start_nx;
  logic [CLK_N-1:0] en;

  slp_wake_qual #(
    .EXT_N     (EXT_N),
    .HOLD_TICKS(HOLD_TICKS)
  ) u_wake (
    .clk  (clk),
    .rst_n(rst_n),
    .state(state_q),
    .src  (wake_src),
    .lvl  (ext_lvl),
    .tick (slow_tick),
    .wake (wake)
  );

  slp_warmup_timer #(
    .W(WARM_W)
  ) u_warm (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (warm_load),
    .load_val(warmup_sel),
    .tick    (slow_tick),
    .done    (warm_done)
  );

  always_comb begin
    state_nx = state_q;
    start_nx = 1'b0;
    case (state_q)
      ST_RUN: begin
        if (sleep_req) begin
          case (mode_sel)
            CODE_LIGHT: begin
              state_nx = ST_LIGHT;
              start_nx = adc_en;
            end
            CODE_QUIET: begin
              state_nx = ST_QUIET;
              start_nx = adc_en;
            end
            CODE_DEEP: state_nx = ST_DEEP;
            default:   state_nx = ST_RUN;
          endcase
        end
      end
      ST_LIGHT, ST_QUIET: if (wake) state_nx = ST_RUN;
      ST_DEEP:            if (wake) state_nx = ST_WARMUP;
      ST_WARMUP:          if (warm_done) state_nx = ST_RUN;
      default:            state_nx = ST_RUN;
    endcase
  end

  assign warm_load = (state_q == ST_DEEP) && (state_nx == ST_WARMUP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_RUN;
      adc_start <= 1'b0;
    end else begin
      state_q   <= state_nx;
      adc_start <= start_nx;
    end
  end

  slp_clk_decode u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .state_nx(state_nx),
    .en      (en)
  );

  assign cpu_clk_en   = en[CK_CPU];
  assign flash_clk_en = en[CK_FLS];
  assign io_clk_en    = en[CK_IO];
  assign adc_clk_en   = en[CK_ADC];
  assign osc_en       = en[CK_OSC];

endmodule

// File: rtl/sleep_clk_ctrl_chk.sv
module sleep_clk_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sleep_req,
  input logic [2:0] mode_sel,
  input logic       cpu_clk_en,
  input logic       flash_clk_en,
  input logic       io_clk_en,
  input logic       adc_clk_en,
  input logic       osc_en,
  input logic       adc_start
);
  assert_light_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en && sleep_req && mode_sel == 3'b000) |=>
      (!cpu_clk_en && !flash_clk_en && io_clk_en && adc_clk_en && osc_en));

  assert_quiet_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en && sleep_req && mode_sel == 3'b001) |=>
      (!cpu_clk_en && !io_clk_en && adc_clk_en && osc_en));

  assert_deep_all_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> !(cpu_clk_en || flash_clk_en || io_clk_en || adc_clk_en));

  assert_reserved_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en && sleep_req && mode_sel > 3'b010) |=> cpu_clk_en);

  assert_no_direct_resume_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |=> !cpu_clk_en);

  assert_start_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);

  assert_start_context_R11: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> (!cpu_clk_en && adc_clk_en && osc_en));

endmodule

bind sleep_clk_ctrl sleep_clk_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sleep_req   (sleep_req),
  .mode_sel    (mode_sel),
  .cpu_clk_en  (cpu_clk_en),
  .flash_clk_en(flash_clk_en),
  .io_clk_en   (io_clk_en),
  .adc_clk_en  (adc_clk_en),
  .osc_en      (osc_en),
  .adc_start   (adc_start)
);

// File: tb/tb_sleep_clk_ctrl.sv
`timescale 1ns/1ps
module tb_sleep_clk_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sleep_req = 1'b0;
  logic [2:0] mode_sel = 3'b0;
  logic       adc_en = 1'b0;
  logic [5:0] wake_src = '0;
  logic [3:0] ext_lvl = '0;
  logic       slow_tick = 1'b0;
  logic [3:0] warmup_sel = '0;
  logic       cpu_clk_en, flash_clk_en, io_clk_en, adc_clk_en, osc_en, adc_start;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  sleep_clk_ctrl dut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .mode_sel(mode_sel),
    .adc_en(adc_en), .wake_src(wake_src), .ext_lvl(ext_lvl),
    .slow_tick(slow_tick), .warmup_sel(warmup_sel),
    .cpu_clk_en(cpu_clk_en), .flash_clk_en(flash_clk_en), .io_clk_en(io_clk_en),
    .adc_clk_en(adc_clk_en), .osc_en(osc_en), .adc_start(adc_start)
  );

  // State codes for the bench: 0 run, 1 light, 2 quiet, 3 deep, 4 warm-up.
  function automatic logic [4:0] exp_en(int st);
    case (st)
      0: return 5'b11111;
      1: return 5'b11100;
      2: return 5'b11000;
      4: return 5'b10000;
      default: return 5'b00000;
    endcase
  endfunction

  function automatic logic [5:0] exp_mask(int st);
    case (st)
      1: return 6'h3F;
      2: return 6'h07;
      3: return 6'h08;
      default: return 6'h00;
    endcase
  endfunction

  function automatic logic [4:0] en_vec();
    return {osc_en, adc_clk_en, io_clk_en, flash_clk_en, cpu_clk_en};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    sleep_req = 1'b0; wake_src = '0; ext_lvl = '0; slow_tick = 1'b0;
    cyc(2);
    rst_n = 1'b1;
    cyc(1);
  endtask

  task automatic go_sleep(logic [2:0] m, logic a);
    mode_sel = m; adc_en = a; sleep_req = 1'b1;
    cyc(1);
    sleep_req = 1'b0;
  endtask

  task automatic tick1();
    slow_tick = 1'b1;
    cyc(1);
    slow_tick = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(1);
    do_reset();
    chk("R1 enables", 32'(en_vec()), 32'(exp_en(0)));
    chk("R1 adc_start", 32'(adc_start), 32'd0);

    // Mode code sweep with both adc_en values: R2 R3 R4 R5 R11.
    for (int m = 0; m < 8; m++) begin
      for (int a = 0; a < 2; a++) begin
        int st;
        string tag;
        do_reset();
        go_sleep(3'(m), 1'(a));
        st = (m < 3) ? m + 1 : 0;
        tag = (m == 0) ? "R2" : (m == 1) ? "R3" : (m == 2) ? "R4" : "R5";
        chk(tag, 32'(en_vec()), 32'(exp_en(st)));
        chk("R11 pulse", 32'(adc_start), 32'((a == 1) && (m < 2)));
        cyc(1);
        chk("R11 width", 32'(adc_start), 32'd0);
        if (m < 3) begin
          go_sleep(3'((m + 1) % 3), 1'b1);
          chk("R5 asleep", 32'(en_vec()), 32'(exp_en(st)));
          chk("R5 no strobe", 32'(adc_start), 32'd0);
        end
      end
    end

    // Single-source wake sweep: R6 R7 R8.
    warmup_sel = '0;
    for (int m = 0; m < 3; m++) begin
      for (int b = 0; b < 6; b++) begin
        int st;
        logic hit;
        string tag;
        st = m + 1;
        tag = (m == 0) ? "R6" : (m == 1) ? "R7" : "R8";
        do_reset();
        go_sleep(3'(m), 1'b0);
        wake_src = 6'(1 << b);
        cyc(1);
        wake_src = '0;
        hit = exp_mask(st)[b];
        if (!hit)        chk(tag, 32'(en_vec()), 32'(exp_en(st)));
        else if (m < 2)  chk(tag, 32'(en_vec()), 32'(exp_en(0)));
        else begin
          chk("R8 to warm-up", 32'(en_vec()), 32'(exp_en(4)));
          cyc(1);
          chk("R10 zero length", 32'(en_vec()), 32'(exp_en(0)));
        end
        if (!hit) begin
          cyc(2);
          chk(tag, 32'(en_vec()), 32'(exp_en(st)));
        end
      end
    end

    // External lines wake light and quiet sleep at once: R6 R7.
    for (int m = 0; m < 2; m++) begin
      for (int l = 0; l < 4; l++) begin
        do_reset();
        go_sleep(3'(m), 1'b0);
        ext_lvl = 4'(1 << l);
        cyc(1);
        ext_lvl = '0;
        chk((m == 0) ? "R6 line" : "R7 line", 32'(en_vec()), 32'(exp_en(0)));
      end
    end

    // Level hold qualification in deep sleep: R9.
    warmup_sel = '0;
    for (int l = 0; l < 4; l++) begin
      do_reset();
      go_sleep(3'b010, 1'b0);
      ext_lvl = 4'(1 << l);
      cyc(10);
      chk("R9 no ticks", 32'(en_vec()), 32'(exp_en(3)));
      repeat (3) tick1();
      cyc(2);
      chk("R9 three ticks", 32'(en_vec()), 32'(exp_en(3)));
      ext_lvl = '0;
      cyc(1);
      ext_lvl = 4'(1 << l);
      repeat (3) tick1();
      cyc(2);
      chk("R9 restart", 32'(en_vec()), 32'(exp_en(3)));
      tick1();
      cyc(1);
      chk("R9 qualified", 32'(en_vec()), 32'(exp_en(4)));
      ext_lvl = '0;
      cyc(1);
      chk("R10 release", 32'(en_vec()), 32'(exp_en(0)));
    end

    // Warm-up length sweep: R10.
    for (int n = 0; n < 6; n++) begin
      do_reset();
      warmup_sel = 4'(n);
      go_sleep(3'b010, 1'b0);
      wake_src = 6'h08;
      cyc(1);
      wake_src = '0;
      warmup_sel = 4'hF;
      chk("R10 enter", 32'(en_vec()), 32'(exp_en(4)));
      if (n > 0) begin
        cyc(3);
        chk("R10 idle cycles", 32'(en_vec()), 32'(exp_en(4)));
      end
      for (int k = 1; k <= n; k++) begin
        tick1();
        chk("R10 counting", 32'(en_vec()), 32'(exp_en(4)));
      end
      cyc(1);
      chk("R10 done", 32'(en_vec()), 32'(exp_en(0)));
      chk("R11 none on wake", 32'(adc_start), 32'd0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule